// File: doc/BRIEF.md
# Calibration Trigger Request Gate

This block sits inside a central trigger processor and decides when a calibration trigger goes out. Each sub-detector fires its own calibration pulser and raises a one-cycle request on its own line. The gate checks the request against the acceptance mask for the current beam state and confirms that no other calibration trigger is in flight or still inside its spacing window. A request that passes is emitted as a typed calibration trigger a fixed number of cycles later. Requests that do not pass are dropped.

When the true end of beam is signalled and control triggers are enabled, the gate emits a control trigger on the next edge. Sub-detectors can use it, for example, to switch pulser settings. The control trigger overrides any calibration trigger still waiting in the delay line. Each source has a saturating counter of granted requests and a saturating counter of dropped requests, which can be read at the ports.

Top module: `cal_trig_gate`

## Requirements
- R1: While rstN is low and on the first cycle after it, trigValid is 0, trigType is 2'b00 and every granted and dropped counter reads 0.
- R2: A request from an enabled source, sampled at edge k while the gate is free, gives a one-cycle trigValid at edge k+D with trigType 2'b01 and trigSrc equal to the source index. D is delayCycles, and a delayCycles of 0 behaves as 1.
- R3: The enable bit for source i is maskInBeam[i] when beamOn is 1 and maskOffBeam[i] when beamOn is 0. A request from a disabled source is dropped and produces no trigger.
- R4: If several enabled sources request at the same edge, only the lowest-numbered one is granted. The others are counted as dropped.
- R5: After a grant at edge k, every request sampled from edge k+1 up to the emission edge is dropped.
- R6: After a calibration trigger is emitted at edge e, requests sampled at edges e+1 through e+S are dropped, where S is spacingCycles. The first request that can be accepted is at edge e+S+1.
- R7: If endOfBeam and ctrlEnable are both 1 at edge e, the gate emits trigValid with trigType 2'b10 and trigSrc 0 at edge e. It cancels any pending calibration trigger and drops every request sampled at edge e. With ctrlEnable at 0, endOfBeam has no effect.
- R8: The counters for source i sit at bits [i*CNT_W +: CNT_W] of grantCnt and dropCnt. Each counts granted or dropped requests, is updated at the edge where the request is sampled, and saturates at all ones.
- R9: Whenever trigValid is 0, trigType is 2'b00. Two calibration triggers are never emitted on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz trigger clock |
| rstN | input | 1 | Active-low synchronous reset |
| calReq | input | NUM_SRC | One-cycle calibration request per source |
| beamOn | input | 1 | 1 while beam is present |
| endOfBeam | input | 1 | One-cycle strobe at the true end of beam |
| ctrlEnable | input | 1 | Allows the control trigger at end of beam |
| maskInBeam | input | NUM_SRC | Source enables used while beam is present |
| maskOffBeam | input | NUM_SRC | Source enables used while beam is absent |
| delayCycles | input | DLY_W | Request-to-trigger latency in cycles |
| spacingCycles | input | SPC_W | Blocked cycles after each calibration trigger |
| trigValid | output | 1 | Trigger strobe |
| trigType | output | 2 | 2'b01 calibration, 2'b10 control, 2'b00 idle |
| trigSrc | output | SRC_W | Source of a calibration trigger, 0 for control |
| grantCnt | output | NUM_SRC*CNT_W | Per-source granted request counters |
| dropCnt | output | NUM_SRC*CNT_W | Per-source dropped request counters |

## Verification
A table of single-cycle request vectors is applied under both beam states with different masks. It shows whether the correct mask is chosen, whether disabled sources are dropped, and whether the lowest eligible source wins when requests collide. Directed sequences place a second request inside the delay window and at both edges of the spacing window, which checks the exact cycle where the gate reopens. They also drive delays of 0 and 1 to check the latency count. Further sequences raise end of beam while a calibration trigger is pending, to show that the control trigger wins and cancels it, and raise it again with control disabled to show that it has no effect. A long run of dropped requests checks counter saturation.

// File: rtl/cal_gate_pkg.sv
`timescale 1ns/1ps
package cal_gate_pkg;
  localparam logic [1:0] TYPE_IDLE = 2'b00;
  localparam logic [1:0] TYPE_CAL  = 2'b01;
  localparam logic [1:0] TYPE_CTRL = 2'b10;

  typedef struct packed {
    logic fireCal;
    logic fireCtrl;
  } gateStrobes_t;
endpackage

// File: rtl/cal_gate_ctrl.sv
`timescale 1ns/1ps
module cal_gate_ctrl
  import cal_gate_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DLY_W   = 8,
  parameter int SPC_W   = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] calReq,
  input  logic               beamOn,
  input  logic               endOfBeam,
  input  logic               ctrlEnable,
  input  logic [NUM_SRC-1:0] maskInBeam,
  input  logic [NUM_SRC-1:0] maskOffBeam,
  input  logic [DLY_W-1:0]   delayCycles,
  input  logic [SPC_W-1:0]   spacingCycles,
  output gateStrobes_t       strobes,
  output logic [NUM_SRC-1:0] grantVec,
  output logic [NUM_SRC-1:0] dropVec,
  output logic [SRC_W-1:0]   pendSrc
);
  logic               pending;
  logic [DLY_W-1:0]   delayCnt;
  logic [SPC_W-1:0]   spaceCnt;
  logic               ctrlHit;
  logic               gateOpen;
  logic [NUM_SRC-1:0] eligible;
  logic [SRC_W-1:0]   winIdx;
  logic               found;

  assign ctrlHit  = endOfBeam & ctrlEnable;
  assign gateOpen = !pending && (spaceCnt == '0) && !ctrlHit;
  assign eligible = calReq & (beamOn ? maskInBeam : maskOffBeam);

  // fixed priority: lowest index wins
  always_comb begin
    grantVec = '0;
    winIdx   = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (gateOpen && eligible[i] && !found) begin
        grantVec[i] = 1'b1;
        winIdx      = SRC_W'(i);
        found       = 1'b1;
      end
    end
  end

  assign dropVec          = calReq & ~grantVec;
  assign strobes.fireCtrl = ctrlHit;
  assign strobes.fireCal  = pending && (delayCnt == DLY_W'(1)) && !ctrlHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      delayCnt <= '0;
      pendSrc  <= '0;
    end else if (ctrlHit) begin
      pending  <= 1'b0;
      delayCnt <= '0;
    end else if (found) begin
      pending  <= 1'b1;
      delayCnt <= (delayCycles == '0) ? DLY_W'(1) : delayCycles;
      pendSrc  <= winIdx;
    end else if (pending) begin
      if (delayCnt == DLY_W'(1)) pending <= 1'b0;
      delayCnt <= delayCnt - DLY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 spaceCnt <= '0;
    else if (strobes.fireCal)  spaceCnt <= spacingCycles;
    else if (spaceCnt != '0)   spaceCnt <= spaceCnt - SPC_W'(1);
  end
endmodule

// File: rtl/cal_gate_dp.sv
`timescale 1ns/1ps
module cal_gate_dp
  import cal_gate_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gateStrobes_t             strobes,
  input  logic [NUM_SRC-1:0]       grantVec,
  input  logic [NUM_SRC-1:0]       dropVec,
  input  logic [SRC_W-1:0]         pendSrc,
  output logic                     trigValid,
  output logic [1:0]               trigType,
  output logic [SRC_W-1:0]         trigSrc,
  output logic [NUM_SRC*CNT_W-1:0] grantCnt,
  output logic [NUM_SRC*CNT_W-1:0] dropCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigValid <= 1'b0;
      trigType  <= TYPE_IDLE;
      trigSrc   <= '0;
    end else if (strobes.fireCtrl) begin
      trigValid <= 1'b1;
      trigType  <= TYPE_CTRL;
      trigSrc   <= '0;
    end else if (strobes.fireCal) begin
      trigValid <= 1'b1;
      trigType  <= TYPE_CAL;
      trigSrc   <= pendSrc;
    end else begin
      trigValid <= 1'b0;
      trigType  <= TYPE_IDLE;
      trigSrc   <= '0;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cnt
    logic [CNT_W-1:0] grantQ, dropQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        grantQ <= '0;
        dropQ  <= '0;
      end else begin
        if (grantVec[i] && grantQ != CNT_MAX) grantQ <= grantQ + CNT_W'(1);
        if (dropVec[i]  && dropQ  != CNT_MAX) dropQ  <= dropQ  + CNT_W'(1);
      end
    end
    assign grantCnt[i*CNT_W +: CNT_W] = grantQ;
    assign dropCnt[i*CNT_W +: CNT_W]  = dropQ;
  end
endmodule

// File: rtl/cal_trig_gate.sv
`timescale 1ns/1ps
module cal_trig_gate
  import cal_gate_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 8,
  parameter int SPC_W   = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       calReq,
  input  logic                     beamOn,
  input  logic                     endOfBeam,
  input  logic                     ctrlEnable,
  input  logic [NUM_SRC-1:0]       maskInBeam,
  input  logic [NUM_SRC-1:0]       maskOffBeam,
  input  logic [DLY_W-1:0]         delayCycles,
  input  logic [SPC_W-1:0]         spacingCycles,
  output logic                     trigValid,
  output logic [1:0]               trigType,
  output logic [SRC_W-1:0]         trigSrc,
  output logic [NUM_SRC*CNT_W-1:0] grantCnt,
  output logic [NUM_SRC*CNT_W-1:0] dropCnt
);
  gateStrobes_t       strobes;
  logic [NUM_SRC-1:0] grantVec;
  logic [NUM_SRC-1:0] dropVec;
  logic [SRC_W-1:0]   pendSrc;

  cal_gate_ctrl #(.NUM_SRC(NUM_SRC), .DLY_W(DLY_W), .SPC_W(SPC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .calReq(calReq), .beamOn(beamOn),
    .endOfBeam(endOfBeam), .ctrlEnable(ctrlEnable),
    .maskInBeam(maskInBeam), .maskOffBeam(maskOffBeam),
    .delayCycles(delayCycles), .spacingCycles(spacingCycles),
    .strobes(strobes), .grantVec(grantVec), .dropVec(dropVec), .pendSrc(pendSrc)
  );

  cal_gate_dp #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .grantVec(grantVec),
    .dropVec(dropVec), .pendSrc(pendSrc), .trigValid(trigValid),
    .trigType(trigType), .trigSrc(trigSrc), .grantCnt(grantCnt), .dropCnt(dropCnt)
  );
endmodule

// File: rtl/cal_trig_gate_chk.sv
`timescale 1ns/1ps
module cal_trig_gate_chk #(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_SRC-1:0]       calReq,
  input logic                     endOfBeam,
  input logic                     ctrlEnable,
  input logic                     trigValid,
  input logic [1:0]               trigType,
  input logic [NUM_SRC-1:0]       grantVec,
  input logic [NUM_SRC*CNT_W-1:0] grantCnt,
  input logic [NUM_SRC*CNT_W-1:0] dropCnt
);
  p_idle_type_r9: assert property (@(posedge clk) disable iff (!rstN)
    !trigValid |-> trigType == 2'b00);
  p_type_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    trigValid |-> (trigType == 2'b01 || trigType == 2'b10));
  p_ctrl_next_r7: assert property (@(posedge clk) disable iff (!rstN)
    (endOfBeam && ctrlEnable) |=> (trigValid && trigType == 2'b10));
  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec & ~calReq) == '0));
  p_busy_after_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|grantVec) |=> !(|grantVec));
  p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && trigType == 2'b01) |=> !(trigValid && trigType == 2'b01));
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mono
    p_cnt_mono_r8: assert property (@(posedge clk) disable iff (!rstN)
      (grantCnt[i*CNT_W +: CNT_W] >= $past(grantCnt[i*CNT_W +: CNT_W])) &&
      (dropCnt[i*CNT_W +: CNT_W]  >= $past(dropCnt[i*CNT_W +: CNT_W])));
  end
endmodule

bind cal_trig_gate cal_trig_gate_chk #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .calReq(calReq), .endOfBeam(endOfBeam),
  .ctrlEnable(ctrlEnable), .trigValid(trigValid), .trigType(trigType),
  .grantVec(grantVec), .grantCnt(grantCnt), .dropCnt(dropCnt)
);

// File: tb/test_cal_trig_gate.sv
`timescale 1ns/1ps
module test_cal_trig_gate;
  localparam int NS = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] calReq = '0;
  logic beamOn = 1'b1, endOfBeam = 1'b0, ctrlEnable = 1'b0;
  logic [NS-1:0] maskInBeam = 4'b1011, maskOffBeam = 4'b0110;
  logic [7:0] delayCycles = 8'd3, spacingCycles = 8'd2;
  logic trigValid;
  logic [1:0] trigType;
  logic [1:0] trigSrc;
  logic [NS*CW-1:0] grantCnt, dropCnt;

  int nRun = 0, nFail = 0;
  int expGrant [NS];
  int expDrop  [NS];

  always #4 clk = ~clk;

  cal_trig_gate i_cal_trig_gate (
    .clk(clk), .rstN(rstN), .calReq(calReq), .beamOn(beamOn),
    .endOfBeam(endOfBeam), .ctrlEnable(ctrlEnable),
    .maskInBeam(maskInBeam), .maskOffBeam(maskOffBeam),
    .delayCycles(delayCycles), .spacingCycles(spacingCycles),
    .trigValid(trigValid), .trigType(trigType), .trigSrc(trigSrc),
    .grantCnt(grantCnt), .dropCnt(dropCnt)
  );

  // entry: {beamOn, req[3:0], expValid, expSrc[1:0]}
  localparam logic [7:0] VEC [8] = '{
    {1'b1, 4'b0001, 1'b1, 2'd0},
    {1'b1, 4'b0100, 1'b0, 2'd0},
    {1'b1, 4'b1100, 1'b1, 2'd3},
    {1'b1, 4'b1010, 1'b1, 2'd1},
    {1'b0, 4'b0001, 1'b0, 2'd0},
    {1'b0, 4'b0110, 1'b1, 2'd1},
    {1'b0, 4'b1100, 1'b1, 2'd2},
    {1'b1, 4'b1111, 1'b1, 2'd0}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gC(input int i); return int'(grantCnt[i*CW +: CW]); endfunction
  function automatic int dC(input int i); return int'(dropCnt[i*CW +: CW]);  endfunction

  task automatic expectCal(input string req, input int src);
    chk(trigValid == 1'b1, req, trigValid, 1);
    chk(trigType == 2'b01, req, trigType, 1);
    chk(int'(trigSrc) == src, req, trigSrc, src);
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int d0;
    for (int i = 0; i < NS; i++) begin expGrant[i] = 0; expDrop[i] = 0; end
    repeat (3) tick();
    // R1 reset state
    chk(trigValid == 1'b0 && trigType == 2'b00, "R1 outputs in reset", trigType, 0);
    chk(grantCnt == '0 && dropCnt == '0, "R1 counters in reset", gC(0)+dC(0), 0);
    rstN = 1'b1;
    tick();
    chk(trigValid == 1'b0, "R1 after release", trigValid, 0);

    // table walk: R2 R3 R4
    for (int v = 0; v < 8; v++) begin
      beamOn = VEC[v][7];
      calReq = VEC[v][6:3];
      tick();
      calReq = '0;
      for (int s = 0; s < NS; s++) begin
        if (VEC[v][6-(3-s)] || VEC[v][3+s]) begin end
        if (VEC[v][3+s]) begin
          if (VEC[v][2] && int'(VEC[v][1:0]) == s) expGrant[s]++;
          else expDrop[s]++;
        end
      end
      for (int j = 1; j < 3; j++) begin
        tick();
        chk(trigValid == 1'b0, "R2 no early trigger", trigValid, 0);
      end
      tick();
      if (VEC[v][2]) expectCal("R2 R3 R4 table trigger", int'(VEC[v][1:0]));
      else chk(trigValid == 1'b0, "R3 masked request dropped", trigValid, 0);
      repeat (6) tick();
    end
    for (int s = 0; s < NS; s++) begin
      chk(gC(s) == expGrant[s], "R8 grant count", gC(s), expGrant[s]);
      chk(dC(s) == expDrop[s], "R8 drop count", dC(s), expDrop[s]);
    end

    // R2 delay of 0 behaves as 1
    beamOn = 1'b1; delayCycles = 8'd0; spacingCycles = 8'd0;
    calReq = 4'b0010; tick(); calReq = '0;
    tick();
    expectCal("R2 delay zero", 1);
    tick(); tick();

    // R5 request while pending is dropped
    delayCycles = 8'd5;
    d0 = dC(1);
    calReq = 4'b0001; tick(); calReq = '0;
    tick();
    calReq = 4'b0010; tick(); calReq = '0;
    chk(dC(1) == d0 + 1, "R5 busy drop counted", dC(1), d0 + 1);
    tick(); chk(trigValid == 1'b0, "R5 quiet", trigValid, 0);
    tick(); chk(trigValid == 1'b0, "R5 quiet", trigValid, 0);
    tick(); expectCal("R5 original fires", 0);
    repeat (8) tick();
    chk(trigValid == 1'b0, "R5 busy request never fires", trigValid, 0);

    // R6 spacing window edges
    delayCycles = 8'd1; spacingCycles = 8'd3;
    calReq = 4'b0001; tick(); calReq = '0;
    tick(); expectCal("R6 first trigger", 0);
    tick(); tick();
    d0 = dC(0);
    calReq = 4'b0001; tick();
    chk(dC(0) == d0 + 1, "R6 request inside spacing dropped", dC(0), d0 + 1);
    tick(); calReq = '0;
    chk(trigValid == 1'b0, "R6 no trigger from blocked request", trigValid, 0);
    tick(); expectCal("R6 first request after spacing", 0);
    repeat (6) tick();

    // R7 control trigger cancels pending calibration
    delayCycles = 8'd4; spacingCycles = 8'd0; ctrlEnable = 1'b1;
    calReq = 4'b0010; tick(); calReq = '0;
    tick();
    d0 = dC(0);
    endOfBeam = 1'b1; calReq = 4'b0001; tick(); endOfBeam = 1'b0; calReq = '0;
    chk(trigValid == 1'b1 && trigType == 2'b10, "R7 control trigger", trigType, 2);
    chk(trigSrc == 2'd0, "R7 control source", trigSrc, 0);
    chk(dC(0) == d0 + 1, "R7 request at end of beam dropped", dC(0), d0 + 1);
    for (int j = 0; j < 5; j++) begin
      tick();
      chk(trigValid == 1'b0, "R7 pending calibration cancelled", trigValid, 0);
    end
    ctrlEnable = 1'b0;
    endOfBeam = 1'b1; tick(); endOfBeam = 1'b0;
    chk(trigValid == 1'b0, "R7 end of beam ignored when disabled", trigValid, 0);
    tick();
    chk(trigValid == 1'b0 && trigType == 2'b00, "R9 idle type", trigType, 0);

    // R8 saturation of drop counter
    maskInBeam = 4'b0000;
    d0 = gC(3);
    calReq = 4'b1000;
    repeat (300) tick();
    calReq = '0;
    tick();
    chk(dC(3) == 255, "R8 drop counter saturates", dC(3), 255);
    chk(gC(3) == d0, "R8 grant counter unchanged", gC(3), d0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule